// File: doc/BRIEF.md
# Trap Vector Sequencer

This block is a small multi-cycle control unit that carries out a service call and its return for a 16-bit processor. A trap command arrives with an 8-bit vector and the program counter value that fetch has already incremented. That value is the address of the instruction after the trap. The sequencer carries out three steps in a fixed order. First it writes the return address into the linkage register R7. Then it reads the start address of the service routine from a 256-entry table at the bottom of memory. Last it loads that address into the program counter.

A separate return command loads the program counter from R7, which brings execution back to the instruction after the trap. The surrounding processor sees the following connections:

- a memory read port: address, request, data and valid;
- a write port and a read port on R7;
- a program counter load port;
- a busy level and a one-cycle done pulse.

While a sequence runs, new commands are ignored. A memory read that never completes holds the sequencer in its wait step with no timeout.

Top module: `svc_call_seq`

## Requirements
- R1: During and after reset, until a command is accepted, busy, done, memReq, linkWrEn and pcLoad are all 0.
- R2: A trap command (cmdTrap=1 while busy=0) is accepted at a clock edge. In the next cycle linkWrEn is 1 and linkWrData equals the pcIn value captured at acceptance.
- R3: In the cycle after the R7 write, memReq rises. memAddr then equals TABLE_BASE plus the zero-extended 8-bit vector, so with the default base of 0 the address is always in the range 0x0000 to 0x00FF.
- R4: While memReq is 1 and memValid is 0, memReq stays 1 and memAddr stays stable, and pcLoad stays 0. There is no timeout.
- R5: In the cycle after a cycle with memReq=1 and memValid=1, pcLoad is 1 and pcNext equals the memData word sampled at that edge.
- R6: done is 1 for exactly one cycle, in the cycle after pcLoad. busy is 1 from the cycle after acceptance through the done cycle, and 0 in the following cycle.
- R7: During a trap, exactly one R7 write occurs, and it comes before the program counter load. In every cycle, at most one of linkWrEn, memReq, pcLoad and done is 1.
- R8: Commands presented while busy=1 are ignored. They do not change the vector, the return address or the timing of the sequence in progress.
- R9: A return command (cmdRet=1, cmdTrap=0, busy=0) causes the following in the next cycle: pcLoad=1 with pcNext equal to linkRdData, no memory request and no R7 write. The done cycle follows.
- R10: If cmdTrap and cmdRet are both 1 while the sequencer is idle, the trap is taken.
- R11: memValid while memReq is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdTrap | input | 1 | Trap command strobe |
| cmdRet | input | 1 | Return command strobe |
| vecIn | input | 8 | Trap vector |
| pcIn | input | 16 | Incremented program counter (return address) |
| memAddr | output | 16 | Table read address |
| memReq | output | 1 | Table read request, held until valid |
| memData | input | 16 | Read data |
| memValid | input | 1 | Read data valid |
| linkWrEn | output | 1 | R7 write enable |
| linkWrData | output | 16 | R7 write data |
| linkRdData | input | 16 | Current R7 contents |
| pcLoad | output | 1 | Program counter load strobe |
| pcNext | output | 16 | Program counter load value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The assertions check the following on every cycle:
- the held request and stable address during a memory wait;
- the table address range;
- the program counter load after data valid, and done after that load;
- the mutual exclusion of the four step strobes;
- the response of the idle state to a trap or return command.

Three behaviours can be shown only by the bench's scenarios, because they need the values captured at acceptance:
- the exact values: that the saved return address, the fetched target and the R7 value reach the right outputs;
- that commands presented while busy leave those values untouched;
- that a stray valid on the memory port has no effect.

// File: rtl/svc_call_pkg.sv
package svc_call_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SAVE  = 3'd1,
    ST_FETCH = 3'd2,
    ST_LOAD  = 3'd3,
    ST_RET   = 3'd4,
    ST_FIN   = 3'd5
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;     // latch vector and return address
    logic linkWr;      // write R7
    logic memReq;      // table read in flight
    logic takeData;    // latch table word
    logic pcLoad;      // drive program counter load
    logic pcFromLink;  // load value comes from R7
    logic done;
    logic busy;
  } seqStrobes_t;

endpackage

// File: rtl/svc_call_ctrl.sv
module svc_call_ctrl
  import svc_call_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdTrap,
  input  logic        cmdRet,
  input  logic        memValid,
  output seqStrobes_t strobes
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (cmdTrap) begin
          strobes.capture = 1'b1;
          stateNext       = ST_SAVE;
        end else if (cmdRet) begin
          stateNext = ST_RET;
        end
      end
      ST_SAVE: begin
        strobes.busy   = 1'b1;
        strobes.linkWr = 1'b1;
        stateNext      = ST_FETCH;
      end
      ST_FETCH: begin
        strobes.busy   = 1'b1;
        strobes.memReq = 1'b1;
        if (memValid) begin
          strobes.takeData = 1'b1;
          stateNext        = ST_LOAD;
        end
      end
      ST_LOAD: begin
        strobes.busy   = 1'b1;
        strobes.pcLoad = 1'b1;
        stateNext      = ST_FIN;
      end
      ST_RET: begin
        strobes.busy       = 1'b1;
        strobes.pcLoad     = 1'b1;
        strobes.pcFromLink = 1'b1;
        stateNext          = ST_FIN;
      end
      ST_FIN: begin
        strobes.busy = 1'b1;
        strobes.done = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/svc_call_dp.sv
module svc_call_dp
  import svc_call_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int VEC_W      = 8,
  parameter int TABLE_BASE = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [VEC_W-1:0]  vecIn,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] memData,
  input  logic [ADDR_W-1:0] linkRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] linkWrData,
  output logic [ADDR_W-1:0] pcNext
);

  localparam logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(TABLE_BASE);
  localparam int                PAD_W     = ADDR_W - VEC_W;

  logic [VEC_W-1:0]  vecReg;
  logic [ADDR_W-1:0] savedPc;
  logic [ADDR_W-1:0] targetReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecReg    <= '0;
      savedPc   <= '0;
      targetReg <= '0;
    end else begin
      if (strobes.capture) begin
        vecReg  <= vecIn;
        savedPc <= pcIn;
      end
      if (strobes.takeData) targetReg <= memData;
    end
  end

  assign memAddr    = BASE_ADDR + {{PAD_W{1'b0}}, vecReg};
  assign linkWrData = savedPc;
  assign pcNext     = strobes.pcFromLink ? linkRdData : targetReg;

endmodule

// File: rtl/svc_call_seq.sv
module svc_call_seq
  import svc_call_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int VEC_W      = 8,
  parameter int TABLE_BASE = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdTrap,
  input  logic              cmdRet,
  input  logic [VEC_W-1:0]  vecIn,
  input  logic [ADDR_W-1:0] pcIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memReq,
  input  logic [ADDR_W-1:0] memData,
  input  logic              memValid,
  output logic              linkWrEn,
  output logic [ADDR_W-1:0] linkWrData,
  input  logic [ADDR_W-1:0] linkRdData,
  output logic              pcLoad,
  output logic [ADDR_W-1:0] pcNext,
  output logic              busy,
  output logic              done
);

  seqStrobes_t strobes;

  svc_call_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmdTrap  (cmdTrap),
    .cmdRet   (cmdRet),
    .memValid (memValid),
    .strobes  (strobes)
  );

  svc_call_dp #(
    .ADDR_W     (ADDR_W),
    .VEC_W      (VEC_W),
    .TABLE_BASE (TABLE_BASE)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .vecIn      (vecIn),
    .pcIn       (pcIn),
    .memData    (memData),
    .linkRdData (linkRdData),
    .memAddr    (memAddr),
    .linkWrData (linkWrData),
    .pcNext     (pcNext)
  );

  assign memReq   = strobes.memReq;
  assign linkWrEn = strobes.linkWr;
  assign pcLoad   = strobes.pcLoad;
  assign busy     = strobes.busy;
  assign done     = strobes.done;

endmodule

// File: rtl/svc_call_chk.sv
module svc_call_chk #(
  parameter int ADDR_W     = 16,
  parameter int VEC_W      = 8,
  parameter int TABLE_BASE = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdTrap,
  input logic              cmdRet,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memReq,
  input logic              memValid,
  input logic              linkWrEn,
  input logic              pcLoad,
  input logic              busy,
  input logic              done
);

  localparam logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(TABLE_BASE);

  logic [ADDR_W-1:0] tblOffs;
  assign tblOffs = memAddr - BASE_ADDR;

  a_r2_link_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdTrap) |=> (linkWrEn && busy));

  a_r3_addr_in_table: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (tblOffs[ADDR_W-1:VEC_W] == '0));

  a_r3_req_after_link: assert property (@(posedge clk) disable iff (!rstN)
    linkWrEn |=> memReq);

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> (memReq && !pcLoad));

  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> $stable(memAddr));

  a_r5_load_after_valid: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memValid) |=> (pcLoad && !memReq));

  a_r6_done_after_load: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> (done && busy));

  a_r6_idle_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!busy && !done));

  a_r6_busy_until_done: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  a_r7_one_step: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({linkWrEn, memReq, pcLoad, done}));

  a_r9_return_path: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdRet && !cmdTrap) |=> (pcLoad && !memReq && !linkWrEn));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cmdTrap && !cmdRet) |=> !busy);

endmodule

bind svc_call_seq svc_call_chk #(
  .ADDR_W     (ADDR_W),
  .VEC_W      (VEC_W),
  .TABLE_BASE (TABLE_BASE)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .cmdTrap  (cmdTrap),
  .cmdRet   (cmdRet),
  .memAddr  (memAddr),
  .memReq   (memReq),
  .memValid (memValid),
  .linkWrEn (linkWrEn),
  .pcLoad   (pcLoad),
  .busy     (busy),
  .done     (done)
);

// File: tb/svc_call_seq_tb.sv
`timescale 1ns/1ps
module svc_call_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdTrap = 1'b0;
  logic        cmdRet = 1'b0;
  logic [7:0]  vecIn = '0;
  logic [15:0] pcIn = '0;
  logic [15:0] memAddr;
  logic        memReq;
  logic [15:0] memData = '0;
  logic        memValid = 1'b0;
  logic        linkWrEn;
  logic [15:0] linkWrData;
  logic [15:0] linkRdData;
  logic        pcLoad;
  logic [15:0] pcNext;
  logic        busy;
  logic        done;

  always #5 clk = ~clk;

  svc_call_seq dut_i (
    .clk(clk), .rstN(rstN), .cmdTrap(cmdTrap), .cmdRet(cmdRet),
    .vecIn(vecIn), .pcIn(pcIn), .memAddr(memAddr), .memReq(memReq),
    .memData(memData), .memValid(memValid), .linkWrEn(linkWrEn),
    .linkWrData(linkWrData), .linkRdData(linkRdData), .pcLoad(pcLoad),
    .pcNext(pcNext), .busy(busy), .done(done)
  );

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit finished = 0;

  // Bench-side register file entry for R7
  logic [15:0] r7 = 16'h0BAD;
  assign linkRdData = r7;
  always @(posedge clk) if (rstN && linkWrEn) r7 <= linkWrData;

  function automatic logic [15:0] tableWord(input logic [15:0] a);
    return 16'h8000 ^ (a * 16'd7) ^ 16'h0150;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model: phase 0 idle, 1 save, 2 fetch, 3 load, 4 finish, 5 return
  int          mPhase = 0;
  logic [7:0]  mVec = '0;
  logic [15:0] mPc = '0;
  logic [15:0] mTgt = '0;

  always @(posedge clk) begin
    if (!rstN) mPhase = 0;
    else begin
      case (mPhase)
        0: if (cmdTrap) begin mVec = vecIn; mPc = pcIn; mPhase = 1; end
           else if (cmdRet) mPhase = 5;
        1: mPhase = 2;
        2: if (memValid) begin mTgt = memData; mPhase = 3; end
        3: mPhase = 4;
        5: mPhase = 4;
        default: mPhase = 0;
      endcase
    end
  end

  // Memory responder and monitors
  int  rspDelay = 0;
  int  reqCycles = 0;
  bit  strayValid = 0;
  int  linkCnt = 0;
  int  loadCnt = 0;
  int  reqTotal = 0;
  bit  gotLink = 0;
  bit  orderOk = 0;
  logic [15:0] lastPcNext = '0;

  always @(negedge clk) begin
    if (rstN) begin
      check(busy == (mPhase != 0), "R6 busy", {15'd0, busy}, {15'd0, mPhase != 0});
      check(done == (mPhase == 4), "R6 done", {15'd0, done}, {15'd0, mPhase == 4});
      check(linkWrEn == (mPhase == 1), "R2 linkWrEn", {15'd0, linkWrEn}, {15'd0, mPhase == 1});
      if (mPhase == 1) check(linkWrData == mPc, "R2 linkWrData", linkWrData, mPc);
      check(memReq == (mPhase == 2), "R3 memReq", {15'd0, memReq}, {15'd0, mPhase == 2});
      if (mPhase == 2) check(memAddr == {8'd0, mVec}, "R3 memAddr", memAddr, {8'd0, mVec});
      check(pcLoad == (mPhase == 3 || mPhase == 5), "R5 pcLoad", {15'd0, pcLoad},
            {15'd0, (mPhase == 3 || mPhase == 5)});
      if (mPhase == 3) check(pcNext == mTgt, "R5 pcNext", pcNext, mTgt);
      if (mPhase == 5) check(pcNext == r7, "R9 pcNext", pcNext, r7);
    end
    if (linkWrEn) begin linkCnt++; gotLink = 1; end
    if (memReq) reqTotal++;
    if (pcLoad) begin loadCnt++; orderOk = gotLink; lastPcNext = pcNext; end
    if (done) gotLink = 0;
    if (memReq) begin
      if (reqCycles >= rspDelay) begin memValid = 1; memData = tableWord(memAddr); end
      else begin memValid = 0; memData = 16'h5A5A; end
      reqCycles++;
    end else begin
      reqCycles = 0;
      memValid = strayValid;
      memData = 16'hDEAD;
    end
  end

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic doTrap(input logic [7:0] v, input logic [15:0] pc, input int dly);
    rspDelay = dly;
    @(posedge clk); #1;
    cmdTrap = 1; vecIn = v; pcIn = pc;
    @(posedge clk); #1;
    cmdTrap = 0;
    waitIdle();
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finishRun();
    end
  end

  initial begin
    int lc, ldc, rq;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(!busy && !done && !memReq && !linkWrEn && !pcLoad, "R1 reset outputs",
          {11'd0, busy, done, memReq, linkWrEn, pcLoad}, 16'd0);
    rstN = 1;
    repeat (2) @(posedge clk); #1;
    check(!busy && !pcLoad, "R1 idle after reset", {15'd0, busy}, 16'd0);

    // R2 R5 R7: basic trap, immediate response
    lc = linkCnt;
    doTrap(8'h21, 16'h3005, 0);
    check(lastPcNext == tableWord(16'h0021), "R5 target", lastPcNext, tableWord(16'h0021));
    check(r7 == 16'h3005, "R2 R7 value", r7, 16'h3005);
    check(orderOk && (linkCnt - lc == 1), "R7 single write before load",
          16'(linkCnt - lc), 16'd1);

    // R3 top vector boundary, short wait
    doTrap(8'hFF, 16'hFFFF, 2);
    check(lastPcNext == tableWord(16'h00FF), "R3 top entry", lastPcNext, tableWord(16'h00FF));

    // R4 long wait: no load while data is missing
    ldc = loadCnt;
    rspDelay = 40;
    @(posedge clk); #1;
    cmdTrap = 1; vecIn = 8'h00; pcIn = 16'h1234;
    @(posedge clk); #1;
    cmdTrap = 0;
    repeat (25) @(posedge clk);
    #1;
    check(memReq && busy && loadCnt == ldc, "R4 waiting", 16'(loadCnt - ldc), 16'd0);
    waitIdle();
    check(lastPcNext == tableWord(16'h0000), "R4 target after wait", lastPcNext, tableWord(16'h0000));

    // R8: commands during busy are ignored
    lc = linkCnt;
    rspDelay = 1;
    @(posedge clk); #1;
    cmdTrap = 1; vecIn = 8'h25; pcIn = 16'h4000;
    @(posedge clk); #1;
    vecIn = 8'h77; pcIn = 16'h9999; cmdRet = 1;
    repeat (3) @(posedge clk);
    #1;
    cmdTrap = 0; cmdRet = 0;
    waitIdle();
    check(lastPcNext == tableWord(16'h0025), "R8 vector kept", lastPcNext, tableWord(16'h0025));
    check(r7 == 16'h4000 && linkCnt - lc == 1, "R8 return address kept", r7, 16'h4000);

    // R9 return
    rq = reqTotal; lc = linkCnt;
    @(posedge clk); #1;
    cmdRet = 1;
    @(posedge clk); #1;
    cmdRet = 0;
    waitIdle();
    check(lastPcNext == 16'h4000, "R9 return target", lastPcNext, 16'h4000);
    check(reqTotal == rq && linkCnt == lc, "R9 no read or write",
          16'(reqTotal - rq + linkCnt - lc), 16'd0);

    // R10 both commands at once
    lc = linkCnt;
    rspDelay = 0;
    @(posedge clk); #1;
    cmdTrap = 1; cmdRet = 1; vecIn = 8'h23; pcIn = 16'h3100;
    @(posedge clk); #1;
    cmdTrap = 0; cmdRet = 0;
    waitIdle();
    check(linkCnt - lc == 1 && lastPcNext == tableWord(16'h0023), "R10 trap wins",
          lastPcNext, tableWord(16'h0023));

    // R11 stray valid while idle
    ldc = loadCnt;
    strayValid = 1;
    repeat (5) @(posedge clk);
    #1;
    check(!busy && loadCnt == ldc, "R11 stray valid", 16'(loadCnt - ldc), 16'd0);
    strayValid = 0;
    repeat (2) @(posedge clk);

    finishRun();
  end

endmodule